// File: doc/BRIEF.md
# Coherence Response Classifier with Pending-Ack Counter

This block sits on the incoming response path of a first-level cache controller. For each response message it takes the message type, a flag that says whether the sender is another first-level cache, the message's ack-count field and the current state of the line. From these it produces one registered event code, which the controller's state machine then consumes.

The block also keeps a signed pending-ack counter for the single outstanding miss. The counter is cleared when the miss is allocated. Data and ack messages for a line that is waiting for write permission subtract their ack count from it. Acks from peers may arrive before the data that carries the expected total, so the counter can go below zero and is held as a two's-complement value.

A plain data response from a peer cache, arriving while a read miss is pending, needs the directory to be unblocked. The block flags this with a separate strobe next to the event.

Top module: `coh_rsp_sorter`

## Requirements
- R1: After reset, `evt_valid`, `evt_err`, `evt_unblock` and `evt_code` are all zero, and `pend_acks` reads zero.
- R2: A message of type 1 (exclusive data) yields event code 1, whatever the line state, sender flag or counter value.
- R3: A message of type 0 (plain data) whose sender flag is set, with the line in state 1, 2, 3 or 4 (read-miss waits, demand or prefetch, with or without a pending invalidate), yields event code 2 and raises `evt_unblock` in the same cycle. `evt_unblock` is never high with any other code.
- R4: Any other plain-data message yields code 3 when the effective counter minus the ack-count field is zero, and code 4 otherwise.
- R5: A message of type 2 (ack) yields code 5 when the effective counter minus the ack-count field is zero, and code 6 otherwise.
- R6: Only in line states 5, 6, 7 and 8 (write-miss waits: IM, SM and their prefetch forms) do plain-data messages not classified under R3, and ack messages, replace the counter with the effective counter minus the ack-count field. In every other state, and for every other message type, the counter keeps its effective value.
- R7: A message of type 3 (writeback ack) yields code 7 and leaves the counter unchanged.
- R8: A message of type 4 to 7 raises `evt_err` with `evt_valid` and code 0, and leaves the counter unchanged.
- R9: `alloc` sets the counter to zero. When a message arrives in the same cycle, the effective counter for that message is zero, and any subtraction from R6 starts from zero.
- R10: Event outputs are registered. They appear in the cycle after the message is presented and last one cycle. With no message, `evt_valid` and `evt_err` are low and the code is 0.
- R11: The counter is an 8-bit two's-complement value that wraps modulo 256, so that early acks leave a negative value which a later data message can bring back to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc | input | 1 | Miss allocated: clear the pending-ack counter |
| msg_valid | input | 1 | A response message is presented this cycle |
| msg_type | input | 3 | 0 data, 1 exclusive data, 2 ack, 3 writeback ack, 4-7 invalid |
| msg_from_peer | input | 1 | Sender is another first-level cache |
| msg_acks | input | 8 | Signed ack-count field of the message |
| line_state | input | 4 | Line state code (see R3, R6; other codes are idle-like) |
| evt_valid | output | 1 | Registered event strobe |
| evt_code | output | 3 | Registered event code (1..7, 0 when none) |
| evt_unblock | output | 1 | Registered: directory unblock needed |
| evt_err | output | 1 | Registered: message type was invalid |
| pend_acks | output | 8 | Pending-ack counter, signed |

## Verification
Two functions can fall in the same cycle: clearing the counter on allocation, and classifying a message that subtracts from the counter. The bench provokes this by driving `alloc` together with data and ack messages in write-miss states. It does so in directed cases and also at random, against a nonzero or negative prior count. It judges the result by checking that the event was classified against zero and that the new counter is exactly the negated ack field.

// File: rtl/coh_rsp_pkg.sv
package coh_rsp_pkg;

  typedef enum logic [2:0] {
    MT_DATA    = 3'd0,
    MT_DATA_EX = 3'd1,
    MT_ACK     = 3'd2,
    MT_WB_ACK  = 3'd3
  } msg_kind_e;

  typedef enum logic [3:0] {
    LS_IDLE     = 4'd0,
    LS_RD       = 4'd1,
    LS_RD_INV   = 4'd2,
    LS_PF_RD    = 4'd3,
    LS_PF_RDINV = 4'd4,
    LS_WR       = 4'd5,
    LS_UPG      = 4'd6,
    LS_PF_WR    = 4'd7,
    LS_PF_UPG   = 4'd8
  } line_wait_e;

  typedef enum logic [2:0] {
    EV_NONE      = 3'd0,
    EV_EXCL_DATA = 3'd1,
    EV_PEER_DATA = 3'd2,
    EV_DATA_DONE = 3'd3,
    EV_DATA_PART = 3'd4,
    EV_ACK_LAST  = 3'd5,
    EV_ACK_MORE  = 3'd6,
    EV_WB_DONE   = 3'd7
  } rsp_event_e;

  // Line waits for read data (demand or prefetch).
  function automatic logic awaits_read(input logic [3:0] st);
    return (st == LS_RD) || (st == LS_RD_INV) ||
           (st == LS_PF_RD) || (st == LS_PF_RDINV);
  endfunction

  // Line waits for write permission: acks are counted here.
  function automatic logic awaits_write(input logic [3:0] st);
    return (st == LS_WR) || (st == LS_UPG) ||
           (st == LS_PF_WR) || (st == LS_PF_UPG);
  endfunction

  // Remaining acks after this message; wraps in the counter width.
  function automatic logic [7:0] ack_residue(input logic [7:0] pend,
                                             input logic [7:0] acks);
    return pend - acks;
  endfunction

endpackage

// File: rtl/crs_classify.sv
module crs_classify
  import coh_rsp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [2:0]       kind,
  input  logic             from_peer,
  input  logic [3:0]       state,
  input  logic [CNT_W-1:0] pend_eff,
  input  logic [CNT_W-1:0] acks,
  output rsp_event_e       evt,
  output logic             unblock,
  output logic             bad_kind,
  output logic             take_acks,
  output logic [CNT_W-1:0] residue
);

  logic none_left;

  always_comb begin
    residue   = pend_eff - acks;
    none_left = (residue == '0);
    evt       = EV_NONE;
    unblock   = 1'b0;
    bad_kind  = 1'b0;
    take_acks = 1'b0;
    case (kind)
      MT_DATA_EX: evt = EV_EXCL_DATA;
      MT_DATA: begin
        if (awaits_read(state) && from_peer) begin
          evt     = EV_PEER_DATA;
          unblock = 1'b1;
        end else begin
          evt       = none_left ? EV_DATA_DONE : EV_DATA_PART;
          take_acks = awaits_write(state);
        end
      end
      MT_ACK: begin
        evt       = none_left ? EV_ACK_LAST : EV_ACK_MORE;
        take_acks = awaits_write(state);
      end
      MT_WB_ACK: evt = EV_WB_DONE;
      default:   bad_kind = 1'b1;
    endcase
  end

endmodule

// File: rtl/crs_ack_ctr.sv
module crs_ack_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [CNT_W-1:0] residue,
  output logic [CNT_W-1:0] pend_eff,
  output logic [CNT_W-1:0] pend_q
);

  assign pend_eff = clear ? '0 : pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    pend_q <= '0;
    else if (load) pend_q <= residue;
    else           pend_q <= pend_eff;
  end

endmodule

// File: rtl/crs_evt_stage.sv
module crs_evt_stage
  import coh_rsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  rsp_event_e evt_d,
  input  logic       unblock_d,
  input  logic       bad_d,
  output logic       valid_q,
  output logic [2:0] code_q,
  output logic       unblock_q,
  output logic       err_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      code_q    <= 3'd0;
      unblock_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      valid_q   <= fire && !bad_d;
      code_q    <= (fire && !bad_d) ? 3'(evt_d) : 3'd0;
      unblock_q <= fire && unblock_d;
      err_q     <= fire && bad_d;
    end
  end

endmodule

// File: rtl/coh_rsp_sorter.sv
module coh_rsp_sorter
  import coh_rsp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             msg_valid,
  input  logic [2:0]       msg_type,
  input  logic             msg_from_peer,
  input  logic [CNT_W-1:0] msg_acks,
  input  logic [3:0]       line_state,
  output logic             evt_valid,
  output logic [2:0]       evt_code,
  output logic             evt_unblock,
  output logic             evt_err,
  output logic [CNT_W-1:0] pend_acks
);

  rsp_event_e       cls_evt;
  logic             cls_unblock;
  logic             cls_bad;
  logic             cls_take;
  logic [CNT_W-1:0] cls_residue;
  logic [CNT_W-1:0] ctr_eff;
  logic             ctr_load;

  crs_classify #(.CNT_W(CNT_W)) u_classify (
    .kind      (msg_type),
    .from_peer (msg_from_peer),
    .state     (line_state),
    .pend_eff  (ctr_eff),
    .acks      (msg_acks),
    .evt       (cls_evt),
    .unblock   (cls_unblock),
    .bad_kind  (cls_bad),
    .take_acks (cls_take),
    .residue   (cls_residue)
  );

  assign ctr_load = msg_valid && cls_take;

  crs_ack_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (alloc),
    .load     (ctr_load),
    .residue  (cls_residue),
    .pend_eff (ctr_eff),
    .pend_q   (pend_acks)
  );

  crs_evt_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (msg_valid),
    .evt_d     (cls_evt),
    .unblock_d (cls_unblock),
    .bad_d     (cls_bad),
    .valid_q   (evt_valid),
    .code_q    (evt_code),
    .unblock_q (evt_unblock),
    .err_q     (evt_err)
  );

endmodule

// File: rtl/coh_rsp_sorter_chk.sv
module coh_rsp_sorter_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc,
  input logic             msg_valid,
  input logic [2:0]       msg_type,
  input logic [3:0]       line_state,
  input logic             evt_valid,
  input logic [2:0]       evt_code,
  input logic             evt_unblock,
  input logic             evt_err,
  input logic [CNT_W-1:0] pend_acks
);

  logic wr_wait;
  assign wr_wait = (line_state >= 4'd5) && (line_state <= 4'd8);

  assert_excl_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == 3'd1) |=> (evt_valid && evt_code == 3'd1));

  assert_unblock_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_unblock |-> (evt_valid && evt_code == 3'd2));

  assert_keep_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !alloc && !wr_wait) |=> $stable(pend_acks));

  assert_wb_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !alloc && msg_type == 3'd3) |=> (evt_code == 3'd7 && $stable(pend_acks)));

  assert_bad_type_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type[2]) |=> (evt_err && !evt_valid && evt_code == 3'd0));

  assert_alloc_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !msg_valid) |=> (pend_acks == '0));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> (!evt_valid && !evt_err && evt_code == 3'd0));

endmodule

bind coh_rsp_sorter coh_rsp_sorter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc       (alloc),
  .msg_valid   (msg_valid),
  .msg_type    (msg_type),
  .line_state  (line_state),
  .evt_valid   (evt_valid),
  .evt_code    (evt_code),
  .evt_unblock (evt_unblock),
  .evt_err     (evt_err),
  .pend_acks   (pend_acks)
);

// File: tb/coh_rsp_sorter_bench.sv
module coh_rsp_sorter_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc = 1'b0;
  logic       msg_valid = 1'b0;
  logic [2:0] msg_type = 3'd0;
  logic       msg_from_peer = 1'b0;
  logic [7:0] msg_acks = 8'd0;
  logic [3:0] line_state = 4'd0;
  logic       evt_valid;
  logic [2:0] evt_code;
  logic       evt_unblock;
  logic       evt_err;
  logic [7:0] pend_acks;

  int vectors = 0;
  int misses  = 0;
  logic [7:0] model_pend = 8'd0;
  logic       done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_rsp_sorter u_coh_rsp_sorter (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .msg_valid(msg_valid),
    .msg_type(msg_type), .msg_from_peer(msg_from_peer), .msg_acks(msg_acks),
    .line_state(line_state), .evt_valid(evt_valid), .evt_code(evt_code),
    .evt_unblock(evt_unblock), .evt_err(evt_err), .pend_acks(pend_acks)
  );

  function automatic string req_of(input logic v, input logic [2:0] t,
                                   input logic alc);
    if (alc) return "R9";
    if (!v) return "R10";
    case (t)
      3'd0: return "R3/R4";
      3'd1: return "R2";
      3'd2: return "R5";
      3'd3: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string rq, input string what,
                       input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // Apply one cycle of stimulus and compare against the bench's own model.
  task automatic apply(input logic v, input logic [2:0] t, input logic peer,
                       input logic [7:0] a, input logic [3:0] st,
                       input logic alc);
    logic [7:0] eff, res;
    logic       rd_w, wr_w, e_val, e_unb, e_err, take;
    logic [2:0] e_code;
    string      rq;
    @(negedge clk);
    alloc = alc; msg_valid = v; msg_type = t; msg_from_peer = peer;
    msg_acks = a; line_state = st;
    eff  = alc ? 8'd0 : model_pend;
    res  = eff + (~a + 8'd1);
    rd_w = (st inside {4'd1, 4'd2, 4'd3, 4'd4});
    wr_w = (st inside {4'd5, 4'd6, 4'd7, 4'd8});
    e_val = v; e_unb = 1'b0; e_err = 1'b0; e_code = 3'd0; take = 1'b0;
    if (v) begin
      if (t == 3'd1) e_code = 3'd1;
      else if (t == 3'd0) begin
        if (rd_w && peer) begin e_code = 3'd2; e_unb = 1'b1; end
        else begin e_code = (res == 8'd0) ? 3'd3 : 3'd4; take = wr_w; end
      end else if (t == 3'd2) begin
        e_code = (res == 8'd0) ? 3'd5 : 3'd6; take = wr_w;
      end else if (t == 3'd3) e_code = 3'd7;
      else begin e_err = 1'b1; e_val = 1'b0; end
    end
    model_pend = take ? res : eff;
    rq = req_of(v, t, alc);
    @(posedge clk);
    #1;
    alloc = 1'b0; msg_valid = 1'b0;
    check(rq, "evt_valid", int'(evt_valid), int'(e_val));
    check(rq, "evt_code", int'(evt_code), int'(e_code));
    check(rq, "evt_unblock", int'(evt_unblock), int'(e_unb));
    check(rq, "evt_err", int'(evt_err), int'(e_err));
    check(take ? "R6/R11" : rq, "pend_acks", int'(pend_acks), int'(model_pend));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd7741;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", "evt_valid", int'(evt_valid), 0);
    check("R1", "evt_code", int'(evt_code), 0);
    check("R1", "evt_err", int'(evt_err), 0);
    check("R1", "pend_acks", int'(pend_acks), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 exclusive data in several states
    apply(1, 3'd1, 1, 8'd3, 4'd5, 0);
    apply(1, 3'd1, 0, 8'd0, 4'd1, 0);
    // R3 peer data in read waits; R4 non-peer data
    apply(1, 3'd0, 1, 8'd0, 4'd2, 0);
    apply(1, 3'd0, 1, 8'd0, 4'd4, 0);
    apply(1, 3'd0, 0, 8'd0, 4'd1, 0);
    // R11: acks ahead of data drive the counter negative, data restores zero
    apply(0, 3'd0, 0, 8'd0, 4'd5, 1);
    apply(1, 3'd2, 0, 8'd1, 4'd5, 0);
    apply(1, 3'd2, 0, 8'd1, 4'd6, 0);
    apply(1, 3'd0, 0, 8'hFE, 4'd5, 0);
    // R5 last ack after data announced three
    apply(1, 3'd0, 0, 8'hFD, 4'd7, 1);
    apply(1, 3'd2, 0, 8'd1, 4'd7, 0);
    apply(1, 3'd2, 0, 8'd2, 4'd8, 0);
    // R6 ack in idle state leaves counter
    apply(1, 3'd2, 0, 8'd5, 4'd0, 0);
    // R7 writeback ack, R8 invalid types
    apply(1, 3'd3, 0, 8'd4, 4'd9, 0);
    apply(1, 3'd5, 0, 8'd2, 4'd5, 0);
    apply(1, 3'd7, 1, 8'd1, 4'd6, 0);
    // R9 alloc together with an ack over a nonzero count
    apply(1, 3'd2, 0, 8'd9, 4'd5, 0);
    apply(1, 3'd2, 0, 8'd2, 4'd5, 1);
    apply(1, 3'd0, 0, 8'd0, 4'd6, 1);
    // R10 idle cycle
    apply(0, 3'd1, 0, 8'd0, 4'd0, 0);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom(seed); seed = seed + 32'd1;
      apply(r[0] | r[1], (r[4:2] == 3'd7 && r[5]) ? 3'd6 : {1'b0, r[7:6]},
            r[8], {{5{r[11]}}, r[11:9]}, 4'(r[15:12] % 10),
            (r[19:16] == 4'd0));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule